// File: doc/BRIEF.md
# Multi-Mode Timer Output Compare Unit

This block watches the count of a free-running timer that lives elsewhere and drives a single output pin from it. A 3-bit mode input selects one of eight behaviours. The codes are 000 off, 001 single pulse going high, 010 single pulse going low, 011 toggle, 100 delayed single pulse, 101 repeating pulse, 110 plain PWM and 111 PWM with a fault stop. The unit compares the timer value against a primary and a secondary compare word. It also takes the timer's period-match strobe. It produces the pin level, a pin-ownership flag, a one-cycle interrupt pulse and a sticky fault flag.

Each mode sets its own pin level when it is entered and raises its interrupt on its own kind of edge. The two PWM modes hold a working copy of the primary word. That copy is reloaded from the secondary word at every period match, so a new duty value takes effect on a cycle boundary. Mode 111 also watches an active-low fault input. A fault shuts the pin off within the same cycle, and the unit stays shut off until software clears the flag and selects the mode again. When the mode is 000 the pin is handed back to a general-purpose level. Any change of the mode value counts as selecting a mode anew, which also re-arms the single-pulse modes.

Top module: `cmpout_unit`

## Requirements
- R1: During synchronous reset and whenever the mode has been 000 for a clock edge, pin_en is 0, pin_o equals gpio_lvl, irq_o is 0, and (after reset) fault_flag is 0.
- R2: On the clock edge where the mode value differs from the one last registered, the pin takes its entry level. That level is 0 for 001, 100 and 101 and 1 for 010. For 011 the previous level is kept. No interrupt is raised for that edge, and compare matches seen in that cycle are ignored.
- R3: In mode 001 (010), the first cycle with tmr_val equal to cmp_pri drives the pin to 1 (0) at the next edge, with irq_o high for that same cycle only. Later matches change nothing until the mode is changed.
- R4: In mode 011 every primary match inverts the pin, and irq_o pulses in the cycle of each rising or falling change.
- R5: In modes 100 and 101 a primary match takes a low pin high, and a secondary match takes a high pin low. Mode 100 does this once, while mode 101 repeats every timer cycle. irq_o pulses only on the falling change.
- R6: On entry to 110 or 111 the pin is 0 if cmp_pri is zero and 1 otherwise, and cmp_pri becomes the working duty value. At each tmr_pm the working value is loaded from cmp_sec, and the pin goes to 1 if cmp_sec is non-zero and to 0 if it is zero. A later match of tmr_val with the working value drives the pin to 0. When tmr_pm and a match fall in the same cycle, tmr_pm wins.
- R7: Mode 110 never raises irq_o, and fault_n has no effect on the pin or on fault_flag in any mode except 111.
- R8: In mode 111, a low fault_n forces pin_o to 0 in the same cycle and sets fault_flag at the next edge. A high-to-low change of fault_n pulses irq_o. A fault wins over a period match in the same cycle.
- R9: fault_flag stays set until fault_clr is high at an edge with no fault active. After a fault in mode 111 the pin stays 0 through period matches, even once the flag is cleared, until the mode is changed while the flag is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tmr_val | input | TW | Current count of the external timer |
| tmr_pm | input | 1 | One-cycle strobe when the timer reaches its period |
| cmp_pri | input | TW | Primary compare word |
| cmp_sec | input | TW | Secondary compare word, duty buffer in PWM modes |
| mode | input | 3 | Behaviour select, codes as in the requirements |
| gpio_lvl | input | 1 | Level the pin takes when the unit is off |
| fault_n | input | 1 | Fault input, active low |
| fault_clr | input | 1 | Clears the sticky fault flag |
| pin_o | output | 1 | Pin level |
| pin_en | output | 1 | 1 when the unit owns the pin |
| irq_o | output | 1 | One-cycle interrupt pulse |
| fault_flag | output | 1 | Sticky fault indication |

## Verification
In the PWM modes, a period match can fall in the same cycle as a primary match. The bench provokes this by loading a working duty of zero and then strobing tmr_pm with the timer at zero. The pin must rise, which shows that the restart won. A fault can also fall in the same cycle as a period match. The bench pulls fault_n low on the very cycle tmr_pm is high in mode 111. The pin must read 0 while the flag and interrupt both assert, and it must stay low through later period matches until the flag is cleared and the mode is changed.

// File: rtl/cmpout_pkg.sv
package cmpout_pkg;

    typedef enum logic [2:0] {
        OCM_OFF     = 3'b000,
        OCM_ONE_HI  = 3'b001,
        OCM_ONE_LO  = 3'b010,
        OCM_TOGGLE  = 3'b011,
        OCM_DELAY   = 3'b100,
        OCM_PULSE   = 3'b101,
        OCM_PWM     = 3'b110,
        OCM_PWM_FLT = 3'b111
    } ocm_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } pin_edge_t;

    function automatic logic is_pwm(ocm_e m);
        return (m == OCM_PWM) || (m == OCM_PWM_FLT);
    endfunction

    // Pin level taken on the edge a mode is entered
    function automatic logic entry_level(ocm_e m, logic cur, logic pri_nz);
        case (m)
            OCM_ONE_LO:           return 1'b1;
            OCM_TOGGLE:           return cur;
            OCM_PWM, OCM_PWM_FLT: return pri_nz;
            default:              return 1'b0;
        endcase
    endfunction

    // Which pin edges raise the interrupt in a given mode
    function automatic logic edge_irq(ocm_e m, pin_edge_t e);
        case (m)
            OCM_ONE_HI:           return e.rise;
            OCM_ONE_LO:           return e.fall;
            OCM_TOGGLE:           return e.rise | e.fall;
            OCM_DELAY, OCM_PULSE: return e.fall;
            default:              return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cmpout_duty.sv
module cmpout_duty
    import cmpout_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          entry,
    input  ocm_e          mode_q,
    input  logic          tmr_pm,
    input  logic [TW-1:0] tmr_val,
    input  logic [TW-1:0] cmp_pri,
    input  logic [TW-1:0] cmp_sec,
    output logic          hit_pri,
    output logic          hit_sec
);

    logic [TW-1:0] duty_q;
    logic [TW-1:0] pri_eff;

    always_ff @(posedge clk) begin
        if (rst) begin
            duty_q <= '0;
        end else if (entry) begin
            duty_q <= cmp_pri;
        end else if (is_pwm(mode_q) && tmr_pm) begin
            duty_q <= cmp_sec;
        end
    end

    always_comb begin
        pri_eff = is_pwm(mode_q) ? duty_q : cmp_pri;
        hit_pri = (tmr_val == pri_eff);
        hit_sec = (tmr_val == cmp_sec);
    end

endmodule

// File: rtl/cmpout_fault.sv
module cmpout_fault
    import cmpout_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic entry,
    input  ocm_e mode_q,
    input  logic fault_n,
    input  logic fault_clr,
    output logic flag,
    output logic fault_fall,
    output logic force_low
);

    logic fn_q;
    logic blocked_q;
    logic armed_mode;
    logic fault_set;

    always_comb begin
        armed_mode = (mode_q == OCM_PWM_FLT);
        fault_set  = armed_mode && !fault_n;
        fault_fall = armed_mode && !entry && fn_q && !fault_n;
        force_low  = armed_mode && (!fault_n || blocked_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fn_q      <= 1'b1;
            flag      <= 1'b0;
            blocked_q <= 1'b0;
        end else begin
            fn_q <= fault_n;
            if (fault_set) begin
                flag <= 1'b1;
            end else if (fault_clr) begin
                flag <= 1'b0;
            end
            if (fault_set) begin
                blocked_q <= 1'b1;
            end else if (entry && !flag) begin
                blocked_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cmpout_pin.sv
module cmpout_pin
    import cmpout_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      entry,
    input  ocm_e      mode_new,
    input  ocm_e      mode_q,
    input  logic      tmr_pm,
    input  logic      hit_pri,
    input  logic      hit_sec,
    input  logic      pri_nz,
    input  logic      sec_nz,
    input  logic      force_low,
    output logic      pin_q,
    output pin_edge_t edges
);

    logic armed_q;
    logic pin_d;
    logic arm_d;

    always_comb begin
        pin_d = pin_q;
        arm_d = armed_q;
        if (entry) begin
            pin_d = entry_level(mode_new, pin_q, pri_nz);
            arm_d = 1'b1;
        end else begin
            case (mode_q)
                OCM_ONE_HI, OCM_ONE_LO: begin
                    if (armed_q && hit_pri) begin
                        pin_d = (mode_q == OCM_ONE_HI);
                        arm_d = 1'b0;
                    end
                end
                OCM_TOGGLE: begin
                    if (hit_pri) pin_d = ~pin_q;
                end
                OCM_DELAY, OCM_PULSE: begin
                    if (armed_q) begin
                        if (!pin_q && hit_pri) begin
                            pin_d = 1'b1;
                        end else if (pin_q && hit_sec) begin
                            pin_d = 1'b0;
                            if (mode_q == OCM_DELAY) arm_d = 1'b0;
                        end
                    end
                end
                OCM_PWM, OCM_PWM_FLT: begin
                    if (force_low)    pin_d = 1'b0;
                    else if (tmr_pm)  pin_d = sec_nz;
                    else if (hit_pri) pin_d = 1'b0;
                end
                default: ;
            endcase
        end
        edges.rise = !entry && !pin_q && pin_d;
        edges.fall = !entry && pin_q && !pin_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q   <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            pin_q   <= pin_d;
            armed_q <= arm_d;
        end
    end

endmodule

// File: rtl/cmpout_unit.sv
module cmpout_unit
    import cmpout_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] tmr_val,
    input  logic          tmr_pm,
    input  logic [TW-1:0] cmp_pri,
    input  logic [TW-1:0] cmp_sec,
    input  logic [2:0]    mode,
    input  logic          gpio_lvl,
    input  logic          fault_n,
    input  logic          fault_clr,
    output logic          pin_o,
    output logic          pin_en,
    output logic          irq_o,
    output logic          fault_flag
);

    ocm_e      mode_new;
    ocm_e      mode_q;
    logic      entry;
    logic      hit_pri;
    logic      hit_sec;
    logic      fault_fall;
    logic      force_low;
    logic      pin_q;
    pin_edge_t edges;

    assign mode_new = ocm_e'(mode);
    assign entry    = (mode_new != mode_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= OCM_OFF;
            irq_o  <= 1'b0;
        end else begin
            mode_q <= mode_new;
            irq_o  <= !entry && (edge_irq(mode_q, edges) || fault_fall);
        end
    end

    cmpout_duty #(.TW(TW)) u_duty (
        .clk     (clk),
        .rst     (rst),
        .entry   (entry),
        .mode_q  (mode_q),
        .tmr_pm  (tmr_pm),
        .tmr_val (tmr_val),
        .cmp_pri (cmp_pri),
        .cmp_sec (cmp_sec),
        .hit_pri (hit_pri),
        .hit_sec (hit_sec)
    );

    cmpout_fault u_fault (
        .clk        (clk),
        .rst        (rst),
        .entry      (entry),
        .mode_q     (mode_q),
        .fault_n    (fault_n),
        .fault_clr  (fault_clr),
        .flag       (fault_flag),
        .fault_fall (fault_fall),
        .force_low  (force_low)
    );

    cmpout_pin u_pin (
        .clk       (clk),
        .rst       (rst),
        .entry     (entry),
        .mode_new  (mode_new),
        .mode_q    (mode_q),
        .tmr_pm    (tmr_pm),
        .hit_pri   (hit_pri),
        .hit_sec   (hit_sec),
        .pri_nz    (cmp_pri != '0),
        .sec_nz    (cmp_sec != '0),
        .force_low (force_low),
        .pin_q     (pin_q),
        .edges     (edges)
    );

    always_comb begin
        pin_en = (mode_q != OCM_OFF);
        if (!pin_en)        pin_o = gpio_lvl;
        else if (force_low) pin_o = 1'b0;
        else                pin_o = pin_q;
    end

endmodule

// File: rtl/cmpout_chk.sv
module cmpout_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] mode,
    input logic [2:0] mode_q,
    input logic       pin_q,
    input logic       fault_n,
    input logic       fault_clr,
    input logic       pin_o,
    input logic       pin_en,
    input logic       irq_o,
    input logic       fault_flag
);

    AST_OFF_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'b000) |=> !pin_en); // R1

    AST_ENTRY_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mode != mode_q) |=> !irq_o); // R2

    AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 3'b001 && mode == 3'b001 && pin_q) |=> pin_q); // R3

    AST_TOGGLE_IRQ: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 3'b011 && mode == 3'b011) |=> (irq_o == (pin_q != $past(pin_q)))); // R4

    AST_DELAY_RISE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 3'b100 && mode == 3'b100 && !pin_q) |=> !irq_o); // R5

    AST_PWM_SILENT: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 3'b110 && mode == 3'b110) |=> !irq_o); // R7

    AST_FAULT_PIN_LOW: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 3'b111 && !fault_n) |-> !pin_o); // R8

    AST_FAULT_LATCH: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 3'b111 && !fault_n) |=> fault_flag); // R8

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (fault_flag && !fault_clr) |=> fault_flag); // R9

endmodule

bind cmpout_unit cmpout_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .mode_q     (mode_q),
    .pin_q      (pin_q),
    .fault_n    (fault_n),
    .fault_clr  (fault_clr),
    .pin_o      (pin_o),
    .pin_en     (pin_en),
    .irq_o      (irq_o),
    .fault_flag (fault_flag)
);

// File: tb/test_cmpout_unit.sv
`timescale 1ns/1ps
module test_cmpout_unit;

    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [TW-1:0] tmr_val = '0;
    logic          tmr_pm = 1'b0;
    logic [TW-1:0] cmp_pri = '0;
    logic [TW-1:0] cmp_sec = '0;
    logic [2:0]    mode = 3'b000;
    logic          gpio_lvl = 1'b1;
    logic          fault_n = 1'b1;
    logic          fault_clr = 1'b0;
    logic          pin_o, pin_en, irq_o, fault_flag;

    typedef struct {
        logic  pin;
        logic  en;
        logic  irq;
        logic  flag;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 0;

    always #2 clk = ~clk;

    cmpout_unit #(.TW(TW)) i_cmpout_unit (
        .clk(clk), .rst(rst), .tmr_val(tmr_val), .tmr_pm(tmr_pm),
        .cmp_pri(cmp_pri), .cmp_sec(cmp_sec), .mode(mode), .gpio_lvl(gpio_lvl),
        .fault_n(fault_n), .fault_clr(fault_clr), .pin_o(pin_o), .pin_en(pin_en),
        .irq_o(irq_o), .fault_flag(fault_flag)
    );

    // Monitor: compares design outputs just after each edge
    always begin
        @(posedge clk);
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_vec++;
            if (pin_o !== e.pin || pin_en !== e.en || irq_o !== e.irq || fault_flag !== e.flag) begin
                n_bad++;
                $display("FAIL %s: pin/en/irq/flag got %b%b%b%b expected %b%b%b%b",
                         e.tag, pin_o, pin_en, irq_o, fault_flag, e.pin, e.en, e.irq, e.flag);
            end
        end
    end

    // Driver: applies one cycle of stimulus and queues the expected result
    task automatic step(input logic [TW-1:0] tv, input logic pm, input logic fn, input logic clr,
                        input logic ep, input logic een, input logic eirq, input logic efl,
                        input string tag);
        exp_t e;
        tmr_val   = tv;
        tmr_pm    = pm;
        fault_n   = fn;
        fault_clr = clr;
        e.pin = ep; e.en = een; e.irq = eirq; e.flag = efl; e.tag = tag;
        q.push_back(e);
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1 reset state: unit off, pin follows GPIO level
        step(0, 0, 1, 0, 1, 0, 0, 0, "R1 reset");
        rst = 1'b0;
        step(0, 0, 1, 0, 1, 0, 0, 0, "R1 off after reset");

        // R3 active-low single pulse (R2 entry level 1)
        gpio_lvl = 1'b0; cmp_pri = 5; mode = 3'b010;
        step(0, 0, 1, 0, 1, 1, 0, 0, "R2 entry 010");
        step(5, 0, 1, 0, 0, 1, 1, 0, "R3 010 match");
        step(6, 0, 1, 0, 0, 1, 0, 0, "R3 010 irq single");
        step(5, 0, 1, 0, 0, 1, 0, 0, "R3 010 once");

        // R3 active-high single pulse
        mode = 3'b001;
        step(0, 0, 1, 0, 0, 1, 0, 0, "R2 entry 001");
        step(5, 0, 1, 0, 1, 1, 1, 0, "R3 001 match");
        step(6, 0, 1, 0, 1, 1, 0, 0, "R3 001 hold");
        step(5, 0, 1, 0, 1, 1, 0, 0, "R3 001 once");

        // R4 toggle keeps level on entry
        mode = 3'b011;
        step(0, 0, 1, 0, 1, 1, 0, 0, "R2 entry 011 keeps");
        step(5, 0, 1, 0, 0, 1, 1, 0, "R4 toggle fall");
        step(6, 0, 1, 0, 0, 1, 0, 0, "R4 idle");
        step(5, 0, 1, 0, 1, 1, 1, 0, "R4 toggle rise");

        // R5 delayed single pulse
        cmp_pri = 3; cmp_sec = 8; mode = 3'b100;
        step(0, 0, 1, 0, 0, 1, 0, 0, "R2 entry 100 no irq");
        step(3, 0, 1, 0, 1, 1, 0, 0, "R5 delay rise");
        step(8, 0, 1, 0, 0, 1, 1, 0, "R5 delay fall");
        step(3, 0, 1, 0, 0, 1, 0, 0, "R5 delay once");
        step(8, 0, 1, 0, 0, 1, 0, 0, "R5 delay once b");

        // R5 repeating pulse
        mode = 3'b101;
        step(0, 0, 1, 0, 0, 1, 0, 0, "R2 entry 101");
        step(3, 0, 1, 0, 1, 1, 0, 0, "R5 pulse rise");
        step(8, 0, 1, 0, 0, 1, 1, 0, "R5 pulse fall");
        step(3, 0, 1, 0, 1, 1, 0, 0, "R5 pulse rise again");
        step(8, 0, 1, 0, 0, 1, 1, 0, "R5 pulse fall again");

        // R6/R7 plain PWM
        cmp_pri = 0; cmp_sec = 4; mode = 3'b110;
        step(0, 0, 1, 0, 0, 1, 0, 0, "R6 entry zero duty");
        step(1, 0, 1, 0, 0, 1, 0, 0, "R6 idle");
        step(9, 1, 1, 0, 1, 1, 0, 0, "R6 period start");
        step(0, 0, 0, 0, 1, 1, 0, 0, "R7 fault ignored in 110");
        step(4, 0, 1, 0, 0, 1, 0, 0, "R7 duty end no irq");
        cmp_sec = 0;
        step(9, 1, 1, 0, 0, 1, 0, 0, "R6 zero duty load");
        cmp_sec = 6;
        step(0, 1, 1, 0, 1, 1, 0, 0, "R6 period beats match");
        step(6, 0, 1, 0, 0, 1, 0, 0, "R6 new duty end");

        // R8/R9 PWM with fault stop
        cmp_pri = 2; cmp_sec = 5; mode = 3'b111;
        step(0, 0, 1, 0, 1, 1, 0, 0, "R6 entry nonzero duty");
        step(2, 0, 1, 0, 0, 1, 0, 0, "R6 duty end");
        step(9, 1, 1, 0, 1, 1, 0, 0, "R6 period 111");
        step(1, 0, 1, 0, 1, 1, 0, 0, "R6 high");
        step(9, 1, 0, 0, 0, 1, 1, 1, "R8 fault beats period");
        step(0, 0, 1, 0, 0, 1, 0, 1, "R9 blocked");
        step(9, 1, 1, 0, 0, 1, 0, 1, "R9 blocked period");
        step(0, 0, 1, 1, 0, 1, 0, 0, "R9 flag clear");
        step(9, 1, 1, 0, 0, 1, 0, 0, "R9 still blocked");
        mode = 3'b110;
        step(0, 0, 1, 0, 1, 1, 0, 0, "R9 mode change");
        mode = 3'b111;
        step(0, 0, 1, 0, 1, 1, 0, 0, "R9 reentry 111");
        step(2, 0, 1, 0, 0, 1, 0, 0, "R9 running");
        step(9, 1, 1, 0, 1, 1, 0, 0, "R9 period resumes");

        // R1 back to off
        gpio_lvl = 1'b1; mode = 3'b000;
        step(0, 0, 1, 0, 1, 0, 0, 0, "R1 off gpio high");
        gpio_lvl = 1'b0;
        step(0, 0, 1, 0, 0, 0, 0, 0, "R1 off gpio low");

        @(posedge clk); #2;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule